// File: doc/BRIEF.md
# Programmable Bit-Order Line Adapter

This block sits between up to four line-side data streams and a byte-wide cell path, and it works in both directions. Each port is configured on its own. A port can be bit-serial, where one line bit moves per enabled cycle, or octet-aligned, where a whole byte moves per enabled cycle. On receive, serial bits are packed into bytes. On transmit, bytes are unpacked onto the line one bit at a time.

A per-port order control selects where the first line bit lands in the byte: bit 7 or bit 0. In octet mode the same control either passes the byte unchanged or mirrors it. The line clock may be gapped, so only cycles with the clock-enable high move data. On framed lines, a payload qualifier further restricts which enabled cycles count. Configuration changes made in the middle of a serial byte are held back until that byte is complete.

Top module: `line_bit_adapter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every `rx_vld` and `tx_ufl` bit is 0 and `tx_line` is all zero.
- R2: A serial receive port with `cfg_msb`=1 places the first qualified line bit (taken from bit 0 of its `rx_din` slice) at byte bit 7. `rx_vld` goes high in the cycle after the clock edge that samples the eighth qualified bit.
- R3: A serial receive port with `cfg_msb`=0 places the first qualified line bit at byte bit 0 and the eighth at bit 7.
- R4: An octet receive port (`cfg_octet`=1) delivers its `rx_din` slice one cycle after each qualified cycle. The slice is unchanged when `cfg_msb`=1 and bit-mirrored (line bit 7 to byte bit 0) when `cfg_msb`=0.
- R5: A cycle with the port's clock-enable low moves no data, raises no strobe and does not advance the bit count.
- R6: With `cfg_framed`=1, an enabled cycle whose payload qualifier is 0 is skipped like a gapped cycle. With `cfg_framed`=0, the qualifier is ignored.
- R7: `rx_vld` is a one-cycle pulse per completed byte. A serial port raises it exactly once per eight qualified bits.
- R8: Changes to `cfg_octet`, `cfg_msb` or `cfg_framed` made while a serial byte is partly gathered or partly sent take effect only after that byte completes.
- R9: A serial transmit port takes a new byte on the first qualified slot of each byte. `tx_ack` is high in that cycle, before the edge. Bits then appear on bit 0 of its `tx_line` slice, one per qualified slot, each visible the cycle after its slot: byte bit 7 first when `cfg_msb`=1, bit 0 first when `cfg_msb`=0. The upper seven bits are 0.
- R10: An octet transmit port acknowledges and sends one byte per qualified slot. The byte appears on its `tx_line` slice the next cycle, unchanged when `cfg_msb`=1 and mirrored when `cfg_msb`=0.
- R11: A qualified transmit slot at a byte boundary with `tx_rdy` low gives no acknowledge. In the next cycle it raises `tx_ufl` for one cycle and drives the `tx_line` slice to zero.
- R12: Ports are independent. Stimulus or configuration on one port never changes another port's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_octet | input | NPORT | Per port: 1 = octet-aligned, 0 = bit-serial |
| cfg_msb | input | NPORT | Per port: 1 = first line bit / line bit 7 maps to byte bit 7 |
| cfg_framed | input | NPORT | Per port: 1 = honour the payload qualifier |
| rx_ce | input | NPORT | Receive line clock-enable |
| rx_pay | input | NPORT | Receive payload qualifier |
| rx_din | input | NPORT*W | Receive line data, W bits per port (serial uses bit 0) |
| rx_byte | output | NPORT*W | Assembled receive byte per port |
| rx_vld | output | NPORT | One-cycle strobe marking a new `rx_byte` |
| tx_ce | input | NPORT | Transmit line clock-enable |
| tx_pay | input | NPORT | Transmit payload qualifier |
| tx_byte | input | NPORT*W | Byte offered for transmission per port |
| tx_rdy | input | NPORT | `tx_byte` holds a valid byte |
| tx_ack | output | NPORT | Byte taken this cycle |
| tx_line | output | NPORT*W | Transmit line data per port (serial uses bit 0) |
| tx_ufl | output | NPORT | Underflow: a byte was needed but none was offered |

## Verification
The checks assume that all inputs change only between clock edges. They also assume the byte source holds `tx_byte` steady while `tx_rdy` is high and has not yet been acknowledged. The stimulus drives every input half a cycle away from the active edge. The random phase draws new configuration rarely and at any time, including mid-byte, so the deferral rule is exercised without breaking the clocking assumption. The underflow and acknowledge properties rely on `tx_ack` being formed from the current cycle's `tx_rdy` and clock-enable, and the bench samples it one time unit after driving.

// File: rtl/lba_pkg.sv
package lba_pkg;
  typedef struct packed {
    logic octet;
    logic msb_first;
    logic framed;
  } lane_cfg_t;
endpackage

// File: rtl/lba_rx_lane.sv
module lba_rx_lane
  import lba_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_cfg_t    cfg,
  input  logic         ce,
  input  logic         pay,
  input  logic [W-1:0] din,
  output logic [W-1:0] out_byte,
  output logic         out_vld
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  lane_cfg_t     held, eff;
  logic [W-1:0]  acc, acc_nx, din_rev;
  logic          slot;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign din_rev[i] = din[W-1-i];
  end

  // configuration follows the inputs only at a byte boundary
  assign eff    = (cnt == '0) ? cfg : held;
  assign slot   = ce & (~eff.framed | pay);
  assign acc_nx = eff.msb_first ? {acc[W-2:0], din[0]} : {din[0], acc[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      held     <= '0;
      acc      <= '0;
      out_byte <= '0;
      out_vld  <= 1'b0;
    end else begin
      held    <= eff;
      out_vld <= 1'b0;
      if (slot) begin
        if (eff.octet) begin
          out_byte <= eff.msb_first ? din : din_rev;
          out_vld  <= 1'b1;
        end else begin
          acc <= acc_nx;
          if (cnt == LAST) begin
            cnt      <= '0;
            out_byte <= acc_nx;
            out_vld  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lba_tx_lane.sv
module lba_tx_lane
  import lba_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_cfg_t    cfg,
  input  logic         ce,
  input  logic         pay,
  input  logic [W-1:0] byte_in,
  input  logic         byte_rdy,
  output logic         byte_ack,
  output logic [W-1:0] line,
  output logic         underflow
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  lane_cfg_t     held, eff;
  logic [W-1:0]  sr, in_rev;
  logic          slot, at_edge;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign in_rev[i] = byte_in[W-1-i];
  end

  assign eff      = (cnt == '0) ? cfg : held;
  assign slot     = ce & (~eff.framed | pay);
  assign at_edge  = slot & (cnt == '0);
  assign byte_ack = at_edge & byte_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      held      <= '0;
      sr        <= '0;
      line      <= '0;
      underflow <= 1'b0;
    end else begin
      held      <= eff;
      underflow <= 1'b0;
      if (at_edge) begin
        if (!byte_rdy) begin
          underflow <= 1'b1;
          line      <= '0;
        end else if (eff.octet) begin
          line <= eff.msb_first ? byte_in : in_rev;
        end else begin
          line <= {{(W-1){1'b0}}, (eff.msb_first ? byte_in[W-1] : byte_in[0])};
          sr   <= eff.msb_first ? (byte_in << 1) : (byte_in >> 1);
          cnt  <= CW'(1);
        end
      end else if (slot) begin
        line <= {{(W-1){1'b0}}, (eff.msb_first ? sr[W-1] : sr[0])};
        sr   <= eff.msb_first ? (sr << 1) : (sr >> 1);
        cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/line_bit_adapter.sv
module line_bit_adapter
  import lba_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   cfg_octet,
  input  logic [NPORT-1:0]   cfg_msb,
  input  logic [NPORT-1:0]   cfg_framed,
  input  logic [NPORT-1:0]   rx_ce,
  input  logic [NPORT-1:0]   rx_pay,
  input  logic [NPORT*W-1:0] rx_din,
  output logic [NPORT*W-1:0] rx_byte,
  output logic [NPORT-1:0]   rx_vld,
  input  logic [NPORT-1:0]   tx_ce,
  input  logic [NPORT-1:0]   tx_pay,
  input  logic [NPORT*W-1:0] tx_byte,
  input  logic [NPORT-1:0]   tx_rdy,
  output logic [NPORT-1:0]   tx_ack,
  output logic [NPORT*W-1:0] tx_line,
  output logic [NPORT-1:0]   tx_ufl
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    lane_cfg_t pcfg;
    assign pcfg = '{octet: cfg_octet[p], msb_first: cfg_msb[p], framed: cfg_framed[p]};

    lba_rx_lane #(.W(W)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .cfg     (pcfg),
      .ce      (rx_ce[p]),
      .pay     (rx_pay[p]),
      .din     (rx_din[p*W +: W]),
      .out_byte(rx_byte[p*W +: W]),
      .out_vld (rx_vld[p])
    );

    lba_tx_lane #(.W(W)) u_tx (
      .clk      (clk),
      .rst      (rst),
      .cfg      (pcfg),
      .ce       (tx_ce[p]),
      .pay      (tx_pay[p]),
      .byte_in  (tx_byte[p*W +: W]),
      .byte_rdy (tx_rdy[p]),
      .byte_ack (tx_ack[p]),
      .line     (tx_line[p*W +: W]),
      .underflow(tx_ufl[p])
    );
  end
endmodule

// File: rtl/lba_chk.sv
module lba_chk #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] rx_ce,
  input logic [NP-1:0] rx_vld,
  input logic [NP-1:0] tx_ce,
  input logic [NP-1:0] tx_rdy,
  input logic [NP-1:0] tx_ack,
  input logic [NP-1:0] tx_ufl
);
  for (genvar p = 0; p < NP; p++) begin : g_chk
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!rx_vld[p] && !tx_ufl[p])); // R1
    AST_VLD_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
      rx_vld[p] |-> $past(rx_ce[p])); // R5
    AST_ACK_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
      tx_ack[p] |-> (tx_rdy[p] && tx_ce[p])); // R9
    AST_UFL_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
      tx_ufl[p] |-> ($past(tx_ce[p]) && !$past(tx_ack[p]))); // R11
    AST_ACK_NO_UFL: assert property (@(posedge clk) disable iff (rst)
      tx_ack[p] |=> !tx_ufl[p]); // R11
  end
endmodule

bind line_bit_adapter lba_chk #(.NP(NPORT)) u_lba_chk (
  .clk   (clk),
  .rst   (rst),
  .rx_ce (rx_ce),
  .rx_vld(rx_vld),
  .tx_ce (tx_ce),
  .tx_rdy(tx_rdy),
  .tx_ack(tx_ack),
  .tx_ufl(tx_ufl)
);

// File: tb/tb_line_bit_adapter.sv
module tb_line_bit_adapter;
  localparam int NP = 4;
  localparam int W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NP-1:0]   cfg_octet, cfg_msb, cfg_framed;
  logic [NP-1:0]   rx_ce, rx_pay, rx_vld, tx_ce, tx_pay, tx_rdy, tx_ack, tx_ufl;
  logic [NP*W-1:0] rx_din, rx_byte, tx_byte, tx_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench reference state
  int       m_rc [NP];
  logic [7:0] m_ra [NP];
  logic     m_ro [NP], m_rm [NP], m_rf [NP];
  int       m_tc [NP];
  logic [7:0] m_ts [NP];
  logic     m_to [NP], m_tm [NP], m_tf [NP];
  logic     e_rv [NP], e_tu [NP];
  logic [7:0] e_rb [NP], e_tl [NP];

  line_bit_adapter #(.NPORT(NP), .W(W)) dut (
    .clk(clk), .rst(rst), .cfg_octet(cfg_octet), .cfg_msb(cfg_msb),
    .cfg_framed(cfg_framed), .rx_ce(rx_ce), .rx_pay(rx_pay), .rx_din(rx_din),
    .rx_byte(rx_byte), .rx_vld(rx_vld), .tx_ce(tx_ce), .tx_pay(tx_pay),
    .tx_byte(tx_byte), .tx_rdy(tx_rdy), .tx_ack(tx_ack), .tx_line(tx_line),
    .tx_ufl(tx_ufl)
  );

  function automatic logic [7:0] mirror(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int p,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port%0d %s actual=%0h expected=%0h", tag, p, what, act, exp);
    end
  endtask

  // one clock: inputs already driven at the preceding negedge
  task automatic cyc(input string tag);
    logic o, m, f, s, a;
    logic [7:0] d, b;
    #1;
    for (int p = 0; p < NP; p++) begin
      o = (m_tc[p] == 0) ? cfg_octet[p] : m_to[p];
      f = (m_tc[p] == 0) ? cfg_framed[p] : m_tf[p];
      s = tx_ce[p] && (!f || tx_pay[p]);
      a = !rst && s && (m_tc[p] == 0) && tx_rdy[p];
      chk(tag, "tx_ack", p, tx_ack[p], a);
    end
    for (int p = 0; p < NP; p++) begin
      if (rst) begin
        m_rc[p] = 0; m_ra[p] = 0; m_ro[p] = 0; m_rm[p] = 0; m_rf[p] = 0;
        m_tc[p] = 0; m_ts[p] = 0; m_to[p] = 0; m_tm[p] = 0; m_tf[p] = 0;
        e_rv[p] = 0; e_rb[p] = 0; e_tu[p] = 0; e_tl[p] = 0;
      end else begin
        // receive
        o = (m_rc[p] == 0) ? cfg_octet[p]  : m_ro[p];
        m = (m_rc[p] == 0) ? cfg_msb[p]    : m_rm[p];
        f = (m_rc[p] == 0) ? cfg_framed[p] : m_rf[p];
        m_ro[p] = o; m_rm[p] = m; m_rf[p] = f;
        e_rv[p] = 0;
        d = rx_din[p*W +: W];
        if (rx_ce[p] && (!f || rx_pay[p])) begin
          if (o) begin
            e_rb[p] = m ? d : mirror(d);
            e_rv[p] = 1;
          end else begin
            m_ra[p][m ? 7 - m_rc[p] : m_rc[p]] = d[0];
            m_rc[p]++;
            if (m_rc[p] == 8) begin
              e_rb[p] = m_ra[p]; e_rv[p] = 1; m_rc[p] = 0;
            end
          end
        end
        // transmit
        o = (m_tc[p] == 0) ? cfg_octet[p]  : m_to[p];
        m = (m_tc[p] == 0) ? cfg_msb[p]    : m_tm[p];
        f = (m_tc[p] == 0) ? cfg_framed[p] : m_tf[p];
        m_to[p] = o; m_tm[p] = m; m_tf[p] = f;
        e_tu[p] = 0;
        b = tx_byte[p*W +: W];
        if (tx_ce[p] && (!f || tx_pay[p])) begin
          if (m_tc[p] == 0) begin
            if (!tx_rdy[p]) begin
              e_tu[p] = 1; e_tl[p] = 0;
            end else if (o) begin
              e_tl[p] = m ? b : mirror(b);
            end else begin
              m_ts[p] = b;
              e_tl[p] = {7'b0, m ? b[7] : b[0]};
              m_tc[p] = 1;
            end
          end else begin
            e_tl[p] = {7'b0, m ? m_ts[p][7 - m_tc[p]] : m_ts[p][m_tc[p]]};
            m_tc[p] = (m_tc[p] == 7) ? 0 : m_tc[p] + 1;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk(tag, "rx_vld", p, rx_vld[p], e_rv[p]);
      if (e_rv[p]) chk(tag, "rx_byte", p, rx_byte[p*W +: W], e_rb[p]);
      chk(tag, "tx_line", p, tx_line[p*W +: W], e_tl[p]);
      chk(tag, "tx_ufl", p, tx_ufl[p], e_tu[p]);
    end
  endtask

  task automatic idle_inputs();
    rx_ce = '0; rx_pay = '0; rx_din = '0;
    tx_ce = '0; tx_pay = '0; tx_rdy = '0; tx_byte = '0;
  endtask

  // feed one serial byte into receive port p, in the given line order
  task automatic feed_rx(input string tag, input int p, input logic [7:0] v,
                         input logic first_is_b7);
    for (int i = 0; i < 8; i++) begin
      rx_ce[p] = 1'b1;
      rx_din[p*W +: W] = {7'b0, first_is_b7 ? v[7-i] : v[i]};
      cyc(tag);
    end
    rx_ce[p] = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    logic [7:0] got;
    seed = $urandom(32'd24681);
    cfg_octet = '0; cfg_msb = '0; cfg_framed = '0;
    idle_inputs();
    @(negedge clk);

    // R1: reset state
    rst = 1'b1;
    repeat (3) cyc("R1");
    rst = 1'b0;
    cyc("R1");
    chk("R1", "rx_vld all", 0, rx_vld, 0);
    chk("R1", "tx_ufl all", 0, tx_ufl, 0);
    chk("R1", "tx_line all", 0, tx_line, 0);

    // R2 / R7: serial msb-first on port 0
    cfg_msb = 4'b0001;
    feed_rx("R2", 0, 8'hA5, 1'b1);
    chk("R2", "byte A5", 0, rx_byte[7:0], 8'hA5);
    chk("R2", "vld", 0, rx_vld[0], 1);
    cyc("R7");
    chk("R7", "vld single pulse", 0, rx_vld[0], 0);

    // R3: serial lsb-first on port 1
    feed_rx("R3", 1, 8'h3C, 1'b0);
    chk("R3", "byte 3C", 1, rx_byte[15:8], 8'h3C);

    // R4 / R12: octet ports 2 (direct) and 3 (mirrored)
    cfg_octet = 4'b1100; cfg_msb = 4'b0101;
    rx_ce = 4'b1100; rx_din = {8'h12, 8'h12, 8'hFF, 8'hFF};
    cyc("R4");
    chk("R4", "octet direct", 2, rx_byte[23:16], 8'h12);
    chk("R4", "octet mirror", 3, rx_byte[31:24], 8'h48);
    chk("R12", "idle ports quiet", 0, rx_vld[1:0], 0);
    idle_inputs();

    // R5: gapped enable on port 0
    cfg_octet = '0; cfg_msb = 4'b0001;
    for (int i = 0; i < 8; i++) begin
      rx_ce[0] = 1'b0; rx_din[7:0] = 8'hFF;
      cyc("R5");
      chk("R5", "no strobe on gap", 0, rx_vld[0], 0);
      rx_ce[0] = 1'b1; rx_din[7:0] = {7'b0, (8'hC3 >> (7 - i)) & 8'h1};
      cyc("R5");
    end
    chk("R5", "byte C3", 0, rx_byte[7:0], 8'hC3);
    idle_inputs();

    // R6: framed qualifier honoured, then ignored when unframed
    cfg_framed = 4'b0001;
    for (int i = 0; i < 8; i++) begin
      rx_ce[0] = 1'b1; rx_pay[0] = 1'b0; rx_din[7:0] = 8'h01;
      cyc("R6");
      rx_pay[0] = 1'b1; rx_din[7:0] = {7'b0, (8'h5A >> (7 - i)) & 8'h1};
      cyc("R6");
    end
    chk("R6", "framed byte 5A", 0, rx_byte[7:0], 8'h5A);
    cfg_framed = '0; rx_pay = '0;
    feed_rx("R6", 0, 8'h0F, 1'b1);
    chk("R6", "unframed byte 0F", 0, rx_byte[7:0], 8'h0F);

    // R8: mode change mid-byte is deferred
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin cfg_octet[0] = 1'b1; cfg_msb[0] = 1'b0; end
      rx_ce[0] = 1'b1; rx_din[7:0] = {7'b0, (8'hE7 >> (7 - i)) & 8'h1};
      cyc("R8");
    end
    chk("R8", "old mode byte E7", 0, rx_byte[7:0], 8'hE7);
    rx_din[7:0] = 8'h01;
    cyc("R8");
    chk("R8", "new mode mirrored", 0, rx_byte[7:0], 8'h80);
    idle_inputs();

    // R9: serial transmit on port 0 (msb) and port 1 (lsb)
    cfg_octet = '0; cfg_msb = 4'b0001;
    tx_byte[15:0] = {8'h2D, 8'hB4};
    tx_ce[1:0] = 2'b11; tx_rdy[1:0] = 2'b11;
    begin
      logic [7:0] g1;
      got = 0; g1 = 0;
      for (int i = 0; i < 8; i++) begin
        if (i == 1) tx_rdy[1:0] = 2'b00;
        cyc("R9");
        got = {got[6:0], tx_line[0]};
        g1  = {tx_line[8], g1[7:1]};
      end
      chk("R9", "msb-first bits", 0, got, 8'hB4);
      chk("R9", "lsb-first bits", 1, g1, 8'h2D);
    end
    // R11: next boundary with nothing offered
    cyc("R11");
    chk("R11", "underflow", 0, tx_ufl[0], 1);
    chk("R11", "line zero", 0, tx_line[7:0], 0);
    idle_inputs();

    // R10: octet transmit, direct and mirrored
    cfg_octet = 4'b1100; cfg_msb = 4'b0100;
    tx_ce = 4'b1100; tx_rdy = 4'b1100; tx_byte = {8'h6E, 8'h6E, 16'h0};
    cyc("R10");
    chk("R10", "octet direct", 2, tx_line[23:16], 8'h6E);
    chk("R10", "octet mirror", 3, tx_line[31:24], 8'h76);
    idle_inputs();

    // R12: random traffic on all ports
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 63) == 0) begin
        cfg_octet = NP'($urandom); cfg_msb = NP'($urandom); cfg_framed = NP'($urandom);
      end
      rx_ce = NP'($urandom); rx_pay = NP'($urandom); rx_din = $urandom;
      tx_ce = NP'($urandom); tx_pay = NP'($urandom);
      for (int p = 0; p < NP; p++) begin
        if (!tx_rdy[p] || tx_ack[p]) begin
          tx_rdy[p] = ($urandom_range(0, 3) != 0);
          tx_byte[p*W +: W] = 8'($urandom);
        end
      end
      cyc("R12");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule